// File: doc/BRIEF.md
# RGB565 Grayscale Packing Engine

This engine masters a single-port synchronous memory and turns a 24x24 colour picture into an 8-bit grayscale picture. Each source word carries one pixel with red in its top five bits, green in the middle six bits and blue in the bottom five bits. The engine fetches source pixels two at a time and computes a brightness that gives red three times the weight of green or blue. It then stores both results as the two bytes of one output word.

A controller raises `start` for one cycle. The engine holds `busy` high while it reads 576 source words and writes 288 packed words. It then writes a zero word to the top of memory as a completion marker and pulses `done`. Memory reads return their data one cycle after the address is presented. The brightness of the first pixel of a pair is held in a byte register. The second pixel's brightness is computed in the cycle its word returns, and the packed word is written in that same cycle.

Top module: `gray_pack_engine`

## Requirements
- R1: Each 8-bit component is rebuilt from its field, with the missing low bits set to zero. Red is bits 15..11 followed by three zeros. Green is bits 10..5 followed by two zeros. Blue is bits 4..0 followed by three zeros.
- R2: Let S = 3*red + green + blue. The brightness is floor(S*51/256), limited to 255, which gives 0 for a black pixel and 247 for a white pixel.
- R3: Output word k goes to address 1600+k. Its low byte (bits 7..0) is the brightness of source word 1024+2k. Its high byte (bits 15..8) is the brightness of source word 1025+2k.
- R4: A run writes exactly 288 output words in ascending address order. Apart from the completion marker, it writes nothing outside addresses 1600 to 1887. Reads and writes never occur in the same cycle, and the source region is left unchanged.
- R5: After the last output word, the engine writes 0x0000 to address 0xFFF exactly once.
- R6: `busy` is high from the cycle after an accepted `start` through the marker write cycle. `done` is high for exactly one cycle, the cycle right after the marker write, and `busy` is low in that cycle.
- R7: A `start` seen while `busy` is high has no effect. The run neither restarts nor lengthens.
- R8: In the first busy cycle the engine presents a read of address 1024. Every output word takes three cycles (two reads and one write), so a run is busy for 865 cycles.
- R9: After reset the engine is idle, with `busy`, `done`, `mem_re` and `mem_we` all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion when idle |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 12 | Memory word address |
| mem_re | output | 1 | Read request, data returns next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the address |

## Verification
The engine is run on a random image whose first words are fixed to black, white, pure red, pure green, pure blue and a faint grey. These fixed words separate the three field extractions from each other and show whether the clamp and rounding give the expected 0 and 247 extremes. A second run uses a gradient pattern with a stray `start` in the middle, which shows up any restart or change in the length of a run. A third run uses only white pixels, which exposes byte-order and address-stride mistakes because every output word must be identical. Each output word is compared in write order against a queue filled from an independent model. Afterwards the source region, a guard word just past the destination and the completion marker are read back and checked.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int PIX_W      = 16;
  localparam int LUMA_W     = 8;
  localparam int LUMA_MUL   = 51;
  localparam int LUMA_SHIFT = 8;
  localparam int SUM_W      = 11;
  localparam int PROD_W     = SUM_W + 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_RD_HI, ST_WR, ST_TRIG
  } gp_state_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } gp_rgb_t;

  function automatic gp_rgb_t gp_unpack(input logic [PIX_W-1:0] px);
    gp_rgb_t c;
    c.r = {px[15:11], 3'b000};
    c.g = {px[10:5], 2'b00};
    c.b = {px[4:0], 3'b000};
    return c;
  endfunction

  function automatic logic [LUMA_W-1:0] gp_luma(input logic [PIX_W-1:0] px);
    gp_rgb_t c;
    logic [SUM_W-1:0]  s;
    logic [PROD_W-1:0] p;
    logic [PROD_W-1:0] q;
    c = gp_unpack(px);
    s = SUM_W'(c.r) * SUM_W'(3) + SUM_W'(c.g) + SUM_W'(c.b);
    p = PROD_W'(s) * PROD_W'(LUMA_MUL);
    q = p >> LUMA_SHIFT;
    if (q > PROD_W'(255)) return 8'hFF;
    return q[LUMA_W-1:0];
  endfunction
endpackage

// File: rtl/gp_luma.sv
module gp_luma
  import gp_pkg::*;
(
  input  logic [PIX_W-1:0]  px,
  output logic [LUMA_W-1:0] lum
);
  always_comb lum = gp_luma(px);

  // R2
  always_comb begin
    if (px == '0) begin
      black_zero_chk: assert (lum == '0);
    end
  end
endmodule

// File: rtl/gp_addr_gen.sv
module gp_addr_gen #(
  parameter int ADDR_W    = 12,
  parameter int SRC_BASE  = 1024,
  parameter int DST_BASE  = 1600,
  parameter int OUT_WORDS = 288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] src_lo_addr,
  output logic [ADDR_W-1:0] src_hi_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              last
);
  localparam int CNT_W = $clog2(OUT_WORDS + 1);
  logic [CNT_W-1:0] k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   k <= '0;
    else if (clr) k <= '0;
    else if (adv) k <= k + 1'b1;
  end

  always_comb begin
    src_lo_addr = ADDR_W'(SRC_BASE) + ADDR_W'({k, 1'b0});
    src_hi_addr = src_lo_addr + ADDR_W'(1);
    dst_addr    = ADDR_W'(DST_BASE) + ADDR_W'(k);
    last        = (k == CNT_W'(OUT_WORDS - 1));
  end

  // R3
  dst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !last) |=> dst_addr == $past(dst_addr) + ADDR_W'(1));
endmodule

// File: rtl/gp_ctrl.sv
module gp_ctrl
  import gp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      last,
  output gp_state_e state
);
  gp_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_RD_LO;
      ST_RD_LO: nxt = ST_RD_HI;
      ST_RD_HI: nxt = ST_WR;
      ST_WR:    nxt = last ? ST_TRIG : ST_RD_LO;
      ST_TRIG:  nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R8
  read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_LO) |=> (state == ST_RD_HI) ##1 (state == ST_WR));
endmodule

// File: rtl/gray_pack_engine.sv
module gray_pack_engine
  import gp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int SRC_BASE  = 1024,
  parameter int DST_BASE  = 1600,
  parameter int OUT_WORDS = 288,
  parameter int TRIG_ADDR = 4095
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata
);
  gp_state_e         state;
  logic              last;
  logic [ADDR_W-1:0] src_lo_addr, src_hi_addr, dst_addr;
  logic [LUMA_W-1:0] lum_now, lo_byte;
  logic              accept, rd_fire, wr_fire, trig_fire, hold_lo;

  assign accept    = (state == ST_IDLE) && start;
  assign rd_fire   = (state == ST_RD_LO) || (state == ST_RD_HI);
  assign hold_lo   = (state == ST_RD_HI);
  assign wr_fire   = (state == ST_WR);
  assign trig_fire = (state == ST_TRIG);

  gp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last), .state(state)
  );

  gp_addr_gen #(
    .ADDR_W(ADDR_W), .SRC_BASE(SRC_BASE), .DST_BASE(DST_BASE), .OUT_WORDS(OUT_WORDS)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(accept), .adv(wr_fire),
    .src_lo_addr(src_lo_addr), .src_hi_addr(src_hi_addr),
    .dst_addr(dst_addr), .last(last)
  );

  gp_luma u_luma (.px(mem_rdata), .lum(lum_now));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_byte <= '0;
      done    <= 1'b0;
    end else begin
      if (hold_lo) lo_byte <= lum_now;
      done <= trig_fire;
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      ST_RD_LO: mem_addr = src_lo_addr;
      ST_RD_HI: mem_addr = src_hi_addr;
      ST_WR: begin
        mem_addr  = dst_addr;
        mem_wdata = {lum_now, lo_byte};
      end
      ST_TRIG:  mem_addr = ADDR_W'(TRIG_ADDR);
      default:  mem_addr = '0;
    endcase
  end

  assign mem_re = rd_fire;
  assign mem_we = wr_fire || trig_fire;
  assign busy   = (state != ST_IDLE);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !trig_fire) |=> busy);
  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  // R4
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R5
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == ADDR_W'(TRIG_ADDR)) |-> mem_wdata == '0);
endmodule

// File: tb/gray_pack_engine_bench.sv
module gray_pack_engine_bench;
  localparam int CLK_P   = 10;
  localparam int SRC     = 1024;
  localparam int DST     = 1600;
  localparam int NOUT    = 288;
  localparam int TRIG    = 4095;
  localparam int RUN_LEN = 3 * NOUT + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, mem_re, mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [15:0] mem [0:4095];
  logic [15:0] src_copy [0:2*NOUT-1];
  logic [15:0] exp_dst [0:NOUT-1];
  logic [15:0] exp_q [$];

  int checks = 0, errors = 0;
  int busy_cyc, done_cnt, trig_cnt, wr_cnt;

  always #(CLK_P/2) clk = ~clk;

  gray_pack_engine u_gray_pack_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_y(input logic [15:0] w);
    int r, g, b, y;
    r = ((w >> 11) & 31) * 8;
    g = ((w >> 5) & 63) * 4;
    b = (w & 31) * 8;
    y = ((r + r + r + g + b) * 51) / 256;
    return (y > 255) ? 255 : y;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cyc++;
      if (done) done_cnt++;
      if (mem_we) begin
        if (mem_addr == 12'(TRIG)) begin
          trig_cnt++;
          chk(mem_wdata == 16'h0, "R5 marker data", mem_wdata, 0);
          chk(exp_q.size() == 0, "R5 marker after last word", exp_q.size(), 0);
        end else if (mem_addr >= 12'(DST) && mem_addr < 12'(DST + NOUT)) begin
          chk(int'(mem_addr) == DST + wr_cnt, "R4 write order", mem_addr, DST + wr_cnt);
          if (exp_q.size() == 0) chk(1'b0, "R4 extra write", mem_addr, 0);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(mem_wdata == e, "R1 R2 R3 packed word", mem_wdata, e);
          end
          wr_cnt++;
        end else begin
          chk(1'b0, "R4 stray write", mem_addr, 0);
        end
      end
    end
  end

  // driver: loads an image, pushes expectations, runs the engine
  task automatic run_image(input int mode, input bit poke);
    bit seen;
    for (int i = 0; i < 2 * NOUT; i++) begin
      logic [15:0] w;
      case (mode)
        0:       w = 16'($urandom);
        1:       w = 16'((i * 113) ^ (i << 7));
        default: w = 16'hFFFF;
      endcase
      if (mode == 0 && i < 6) begin
        case (i)
          0: w = 16'h0000; 1: w = 16'hFFFF; 2: w = 16'hF800;
          3: w = 16'h07E0; 4: w = 16'h001F; default: w = 16'h0841;
        endcase
      end
      mem[SRC + i] = w;
      src_copy[i]  = w;
    end
    for (int k = 0; k < NOUT; k++) mem[DST + k] = 16'hDEAD;
    mem[DST + NOUT] = 16'hA5A5;
    mem[TRIG] = 16'h1234;
    for (int k = 0; k < NOUT; k++) begin
      exp_dst[k] = 16'((ref_y(src_copy[2*k+1]) << 8) | ref_y(src_copy[2*k]));
      exp_q.push_back(exp_dst[k]);
    end
    busy_cyc = 0; done_cnt = 0; trig_cnt = 0; wr_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R8 first read
    chk(mem_re && mem_addr == 12'(SRC), "R8 first read address", mem_addr, SRC);
    chk(busy, "R6 busy after start", busy, 1);
    if (poke) begin
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    seen = 0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, "R6 done reached", seen, 1);
    repeat (3) @(negedge clk);
    chk(busy_cyc == RUN_LEN, "R8 R7 busy cycles", busy_cyc, RUN_LEN);
    chk(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
    chk(trig_cnt == 1, "R5 one marker write", trig_cnt, 1);
    chk(wr_cnt == NOUT, "R4 output word count", wr_cnt, NOUT);
    chk(!busy, "R7 no restart", busy, 0);
    chk(mem[TRIG] == 16'h0, "R5 marker in memory", mem[TRIG], 0);
    chk(mem[DST + NOUT] == 16'hA5A5, "R4 guard word", mem[DST + NOUT], 16'hA5A5);
    for (int i = 0; i < 2 * NOUT; i++)
      if (mem[SRC + i] != src_copy[i])
        chk(1'b0, "R4 source intact", mem[SRC + i], src_copy[i]);
    for (int k = 0; k < NOUT; k++)
      if (mem[DST + k] != exp_dst[k])
        chk(1'b0, "R3 stored word", mem[DST + k], exp_dst[k]);
    exp_q.delete();
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!busy && !done && !mem_we && !mem_re, "R9 reset idle",
        {busy, done, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R9 idle after reset", {busy, done}, 0);
    // R1 R2 model spot values
    chk(ref_y(16'hFFFF) == 247, "R2 white model", ref_y(16'hFFFF), 247);
    run_image(0, 1'b0);
    chk(exp_dst[0] == 16'hF700, "R3 black low white high", exp_dst[0], 16'hF700);
    run_image(1, 1'b1);
    run_image(2, 1'b0);
    chk(exp_dst[NOUT-1] == 16'hF7F7, "R2 white pair", exp_dst[NOUT-1], 16'hF7F7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule